// File: doc/BRIEF.md
# Indexed Host Register Port with Programmed Sample Transfer

This block is the byte-wide host side of an audio converter. A host reaches it with an active-low chip select and active-low read and write strobes, plus a two-bit address. Through that port it can set an index pointer and reach a bank of indirect control bytes through it. It can also poll a status byte and move single sample bytes by programmed transfer: playback bytes are written in and capture bytes are read out. The strobes are asynchronous to the block clock, so they pass through a synchronizer first. A write takes effect on the synchronized rising edge of the write strobe.

While a direct-memory acknowledge input is asserted (low), the port ignores every host cycle. It does not drive the bus, does not write, and clears no flag. A configuration byte holds a direction-enable bit and a programmed-mode bit for each direction. Data moves in a direction only when both of its bits are set. A single-cycle sample tick from the converter timing sets both ready flags and latches the newest capture byte. On the same tick the two low bits of the pin-control byte are copied to two general-purpose output pins.

Top module: `hp_host_port`

## Requirements
- R1: While chip select and read are both low (after SYNC_STAGES clock edges of synchronization) and both acknowledges are high, `rdata_oe` is 1 and `rdata` carries the addressed byte. At all other times `rdata_oe` is 0 and `rdata` is 0.
- R2: A write takes effect on the synchronized rising edge of `wr_n`, provided `cs_n` is still low at that edge. Asserting `wr_n` low on its own changes nothing.
- R3: If `cap_ack_n` or `pb_ack_n` is low, a host cycle is ignored: no register or output changes, `rdata_oe` stays 0, and no ready flag is cleared.
- R4: The address map is: 0 is the index pointer (its low 4 bits are stored, and the upper bits read as 0), 1 is the indexed control byte, 2 is status, and 3 is sample data.
- R5: Indices 0 to 10 are 8-bit read/write bytes. Indices 11 to 15 read as 0 and ignore writes.
- R6: Index 9 is the configuration byte. Bit 0 enables playback, bit 1 enables capture, bit 6 selects programmed playback and bit 7 selects programmed capture. Playback transfer is active only when bits 0 and 6 are both set.
- R7: Capture transfer is active only when bits 1 and 7 of index 9 are both set. When it is inactive, a read at address 3 returns 0 and leaves the capture-ready flag set.
- R8: A `sample_tick` sets status bit 0 (capture ready) and status bit 1 (playback ready), and latches `adc_byte` into the capture holding byte. Status bits 7 to 2 read as 0.
- R9: A completed read at address 3 while capture transfer is active clears capture ready. A write at address 3 while playback transfer is active loads `dac_byte` and clears playback ready. If playback transfer is inactive, that write leaves `dac_byte` and the flag unchanged. A tick in the same cycle as a clear wins.
- R10: Bits 1:0 of index 10 drive `xout[1:0]`, but only at a `sample_tick`. Between ticks the pins hold their value.
- R11: After reset the index is 0, all control bytes are 0, both flags are 0, and `xout`, `dac_byte` and `rdata_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Direct register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not driven |
| rdata_oe | output | 1 | Read data enable for the external bus driver |
| cap_ack_n | input | 1 | Capture DMA acknowledge, active low |
| pb_ack_n | input | 1 | Playback DMA acknowledge, active low |
| sample_tick | input | 1 | One-cycle pulse per sample period |
| adc_byte | input | 8 | Newest capture byte from the converter |
| dac_byte | output | 8 | Last playback byte accepted |
| xout | output | 2 | General-purpose output pins |

## Verification
The bench uses the default parameters: two synchronizer stages, a 4-bit index with 11 implemented bytes, configuration at index 9 and pins at index 10. These defaults leave five unimplemented index values (11 to 15) available to test read-as-zero and write-ignore. They also keep the strobe-to-effect latency at three edges, so every strobe phase can be held long enough to sample. The bench goes through each single-bit and paired setting of the configuration enables. It runs host cycles with either acknowledge held low, and places ticks around pin writes to show that the pins follow only the tick.

// File: rtl/hp_pkg.sv
package hp_pkg;

  localparam int unsigned BYTE_W = 8;

  // direct address decode
  typedef enum logic [1:0] {
    A_INDEX  = 2'd0,
    A_IDATA  = 2'd1,
    A_STATUS = 2'd2,
    A_PIO    = 2'd3
  } hp_addr_e;

  // configuration byte bit positions
  localparam int unsigned CFG_PB_EN   = 0;
  localparam int unsigned CFG_CAP_EN  = 1;
  localparam int unsigned CFG_PB_PIO  = 6;
  localparam int unsigned CFG_CAP_PIO = 7;

  // host strobe bundle, all idle high
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic cap_ack_n;
    logic pb_ack_n;
  } hp_strobe_t;

  localparam int unsigned STROBE_W = $bits(hp_strobe_t);

  function automatic logic pb_pio_on(input logic [BYTE_W-1:0] cfg);
    return cfg[CFG_PB_EN] & cfg[CFG_PB_PIO];
  endfunction

  function automatic logic cap_pio_on(input logic [BYTE_W-1:0] cfg);
    return cfg[CFG_CAP_EN] & cfg[CFG_CAP_PIO];
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic cap_rdy,
                                                    input logic pb_rdy);
    logic [BYTE_W-1:0] s;
    s    = '0;
    s[0] = cap_rdy;
    s[1] = pb_rdy;
    return s;
  endfunction

endpackage

// File: rtl/hp_strobe_sync.sv
module hp_strobe_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) stg[k] <= '1;
      prev_q <= '1;
    end else begin
      stg[0] <= async_i;
      for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
      prev_q <= stg[LAST];
    end
  end

  assign sync_o = stg[LAST];

  genvar g;
  generate
    for (g = 0; g < int'(W); g++) begin : g_edge
      assign rise_o[g] = stg[LAST][g] & ~prev_q[g];
    end
  endgenerate

endmodule

// File: rtl/hp_ctrl_regs.sv
module hp_ctrl_regs #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned NUM_IDX = 11,
  parameter int unsigned DW      = 8,
  parameter int unsigned CFG_IDX = 9,
  parameter int unsigned PIN_IDX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic             data_we,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] idx_o,
  output logic [DW-1:0]    sel_data_o,
  output logic [DW-1:0]    cfg_o,
  output logic [DW-1:0]    pins_o
);

  localparam int unsigned IDX_SPAN = 1 << IDX_W;

  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    bank [NUM_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= wdata[IDX_W-1:0];
  end

  genvar g;
  generate
    for (g = 0; g < int'(NUM_IDX); g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  bank[g] <= '0;
        else if (data_we && idx_q == IDX_W'(g))      bank[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    sel_data_o = '0;
    for (int k = 0; k < int'(NUM_IDX); k++)
      if (idx_q == IDX_W'(k)) sel_data_o = bank[k];
  end

  assign idx_o  = idx_q;
  assign cfg_o  = bank[CFG_IDX];
  assign pins_o = bank[PIN_IDX];

  initial begin
    if (NUM_IDX > IDX_SPAN || CFG_IDX >= NUM_IDX || PIN_IDX >= NUM_IDX)
      $error("hp_ctrl_regs: index parameters out of range");
  end

endmodule

// File: rtl/hp_pio_path.sv
module hp_pio_path
  import hp_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NPINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DW-1:0]    adc_i,
  input  logic [DW-1:0]    cfg_i,
  input  logic [DW-1:0]    pins_reg_i,
  input  logic             pio_wr_evt,
  input  logic             pio_rd_evt,
  input  logic [DW-1:0]    wdata,
  output logic             cap_ready_o,
  output logic             pb_ready_o,
  output logic [DW-1:0]    cap_hold_o,
  output logic [DW-1:0]    dac_o,
  output logic [NPINS-1:0] xout_o,
  output logic             pb_take_o,
  output logic             cap_take_o
);

  logic cap_rdy_q, pb_rdy_q;
  logic [DW-1:0] cap_q, dac_q;
  logic [NPINS-1:0] pin_q;

  assign pb_take_o  = pio_wr_evt & pb_pio_on(cfg_i);
  assign cap_take_o = pio_rd_evt & cap_pio_on(cfg_i);

  // ready flags: a fresh sample period wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rdy_q <= 1'b0;
      pb_rdy_q  <= 1'b0;
    end else begin
      if (tick)            cap_rdy_q <= 1'b1;
      else if (cap_take_o) cap_rdy_q <= 1'b0;
      if (tick)            pb_rdy_q  <= 1'b1;
      else if (pb_take_o)  pb_rdy_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap_q <= '0;
    else if (tick) cap_q <= adc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dac_q <= '0;
    else if (pb_take_o) dac_q <= wdata;
  end

  // pins follow the control byte only on the sample clock
  genvar g;
  generate
    for (g = 0; g < int'(NPINS); g++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pin_q[g] <= 1'b0;
        else if (tick) pin_q[g] <= pins_reg_i[g];
      end
    end
  endgenerate

  assign cap_ready_o = cap_rdy_q;
  assign pb_ready_o  = pb_rdy_q;
  assign cap_hold_o  = cap_q;
  assign dac_o       = dac_q;
  assign xout_o      = pin_q;

endmodule

// File: rtl/hp_host_port.sv
module hp_host_port
  import hp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned NUM_IDX     = 11,
  parameter int unsigned CFG_IDX     = 9,
  parameter int unsigned PIN_IDX     = 10,
  parameter int unsigned NPINS       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic              cap_ack_n,
  input  logic              pb_ack_n,
  input  logic              sample_tick,
  input  logic [BYTE_W-1:0] adc_byte,
  output logic [BYTE_W-1:0] dac_byte,
  output logic [NPINS-1:0]  xout
);

  hp_strobe_t strobe_raw, strobe_s, strobe_rise;
  logic [STROBE_W-1:0] sync_vec, rise_vec;

  assign strobe_raw = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n,
                        cap_ack_n: cap_ack_n, pb_ack_n: pb_ack_n};

  hp_strobe_sync #(.STAGES(SYNC_STAGES), .W(STROBE_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(strobe_raw),
    .sync_o (sync_vec),
    .rise_o (rise_vec)
  );

  assign strobe_s    = sync_vec;
  assign strobe_rise = rise_vec;

  // named internal events
  logic acks_ok_s, selected, rd_act, wr_evt, rd_end_evt;
  hp_addr_e a_dec;

  assign a_dec      = hp_addr_e'(addr);
  assign acks_ok_s  = strobe_s.cap_ack_n & strobe_s.pb_ack_n;
  assign selected   = ~strobe_s.cs_n & acks_ok_s;
  assign rd_act     = selected & ~strobe_s.rd_n;
  assign wr_evt     = selected & strobe_rise.wr_n;
  assign rd_end_evt = selected & strobe_rise.rd_n;

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sel_data, cfg_byte, pin_byte;

  hp_ctrl_regs #(
    .IDX_W(IDX_W), .NUM_IDX(NUM_IDX), .DW(BYTE_W),
    .CFG_IDX(CFG_IDX), .PIN_IDX(PIN_IDX)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (wr_evt && a_dec == A_INDEX),
    .data_we   (wr_evt && a_dec == A_IDATA),
    .wdata     (wdata),
    .idx_o     (idx_q),
    .sel_data_o(sel_data),
    .cfg_o     (cfg_byte),
    .pins_o    (pin_byte)
  );

  logic cap_ready, pb_ready, pb_take, cap_take;
  logic [BYTE_W-1:0] cap_hold;

  hp_pio_path #(.DW(BYTE_W), .NPINS(NPINS)) u_pio (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (sample_tick),
    .adc_i      (adc_byte),
    .cfg_i      (cfg_byte),
    .pins_reg_i (pin_byte),
    .pio_wr_evt (wr_evt && a_dec == A_PIO),
    .pio_rd_evt (rd_end_evt && a_dec == A_PIO),
    .wdata      (wdata),
    .cap_ready_o(cap_ready),
    .pb_ready_o (pb_ready),
    .cap_hold_o (cap_hold),
    .dac_o      (dac_byte),
    .xout_o     (xout),
    .pb_take_o  (pb_take),
    .cap_take_o (cap_take)
  );

  logic [BYTE_W-1:0] read_mux;

  always_comb begin
    read_mux = '0;
    unique case (a_dec)
      A_INDEX:  read_mux[IDX_W-1:0] = idx_q;
      A_IDATA:  read_mux = sel_data;
      A_STATUS: read_mux = status_byte(cap_ready, pb_ready);
      A_PIO:    read_mux = cap_pio_on(cfg_byte) ? cap_hold : '0;
    endcase
  end

  assign rdata    = rd_act ? read_mux : '0;
  assign rdata_oe = rd_act;

endmodule

// File: rtl/hp_host_port_chk.sv
module hp_host_port_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned NPINS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rdata,
  input logic             rdata_oe,
  input logic [NPINS-1:0] xout,
  input logic             sample_tick,
  input logic [7:0]       dac_byte,
  input logic             cap_ready,
  input logic             pb_ready,
  input logic [IDX_W-1:0] idx_q,
  input logic             acks_ok_s,
  input logic             wr_evt,
  input logic             pb_take,
  input logic             cap_take
);

  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);

  a_r2_index_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> $past(wr_evt));

  a_r3_write_needs_acks: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> $past(acks_ok_s));

  a_r3_read_needs_acks: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> acks_ok_s);

  a_r8_tick_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> cap_ready && pb_ready);

  a_r9_pb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pb_ready) |-> $past(pb_take));

  a_r9_dac_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_byte) |-> $past(pb_take));

  a_r7_cap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_ready) |-> $past(cap_take));

  a_r10_pins_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xout) |-> $past(sample_tick));

endmodule

bind hp_host_port hp_host_port_chk #(.IDX_W(IDX_W), .NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdata      (rdata),
  .rdata_oe   (rdata_oe),
  .xout       (xout),
  .sample_tick(sample_tick),
  .dac_byte   (dac_byte),
  .cap_ready  (cap_ready),
  .pb_ready   (pb_ready),
  .idx_q      (idx_q),
  .acks_ok_s  (acks_ok_s),
  .wr_evt     (wr_evt),
  .pb_take    (pb_take),
  .cap_take   (cap_take)
);

// File: tb/hp_host_port_tb.sv
module hp_host_port_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic rdata_oe;
  logic cap_ack_n = 1'b1, pb_ack_n = 1'b1;
  logic sample_tick = 1'b0;
  logic [7:0] adc_byte = 8'd0;
  logic [7:0] dac_byte;
  logic [1:0] xout;

  always #10 clk = ~clk;

  hp_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .cap_ack_n(cap_ack_n), .pb_ack_n(pb_ack_n), .sample_tick(sample_tick),
    .adc_byte(adc_byte), .dac_byte(dac_byte), .xout(xout)
  );

  int checks = 0;
  int failures = 0;
  bit busy = 1'b1;
  bit done = 1'b0;

  // behavioural reference state
  int m_reg [16];
  int m_idx = 0;
  bit m_cap = 0, m_pb = 0;
  int m_adc = 0, m_dac = 0, m_x = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pb_on();
    return m_reg[9][0] && m_reg[9][6];
  endfunction

  function automatic bit cap_on();
    return m_reg[9][1] && m_reg[9][7];
  endfunction

  function automatic int expect_read(input int a);
    case (a)
      0: return m_idx;
      1: return (m_idx <= 10) ? m_reg[m_idx] : 0;
      2: return (m_pb ? 2 : 0) + (m_cap ? 1 : 0);
      default: return cap_on() ? m_adc : 0;
    endcase
  endfunction

  task automatic host_write(input int a, input int v, input bit ack_low);
    bit ok;
    ok = !ack_low;
    busy = 1'b1;
    @(negedge clk);
    pb_ack_n = !ack_low;
    addr = 2'(a); wdata = 8'(v); cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    pb_ack_n = 1'b1;
    if (ok) begin
      case (a)
        0: m_idx = v & 15;
        1: if (m_idx <= 10) m_reg[m_idx] = v & 255;
        3: if (pb_on()) begin m_dac = v & 255; m_pb = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic host_read(input int a, input bit ack_low, input string req);
    int exp;
    busy = 1'b1;
    exp = expect_read(a);
    @(negedge clk);
    cap_ack_n = !ack_low;
    addr = 2'(a); cs_n = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk({req, " oe"}, int'(rdata_oe), ack_low ? 0 : 1);
    chk({req, " data"}, int'(rdata), ack_low ? 0 : exp);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    cap_ack_n = 1'b1;
    if (!ack_low && a == 3 && cap_on()) m_cap = 0;
    @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic tick(input int v);
    @(negedge clk);
    sample_tick = 1'b1; adc_byte = 8'(v);
    @(posedge clk);
    m_cap = 1; m_pb = 1; m_adc = v; m_x = m_reg[10] & 3;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  // per-clock comparison of the free-running outputs
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      chk("R10 xout", int'(xout), m_x);
      chk("R9 dac_byte", int'(dac_byte), m_dac);
      chk("R1 idle oe", int'(rdata_oe), 0);
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 xout", int'(xout), 0);
    chk("R11 dac", int'(dac_byte), 0);
    chk("R11 oe", int'(rdata_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    busy = 1'b0;
    host_read(2, 0, "R11 status");
    host_read(0, 0, "R11 index");
    // R4 / R2 address map and write path
    host_write(0, 5, 0);
    host_read(0, 0, "R4 index");
    host_write(1, 8'hA5, 0);
    host_read(1, 0, "R2 indexed data");
    host_write(0, 3, 0);
    host_write(1, 8'h3C, 0);
    host_write(0, 5, 0);
    host_read(1, 0, "R5 byte 5 kept");
    host_write(0, 8'hF2, 0);
    host_read(0, 0, "R4 index upper bits");
    // R5 unimplemented index
    host_write(0, 12, 0);
    host_write(1, 8'h77, 0);
    host_read(1, 0, "R5 unused index");
    // R3 acknowledge low
    host_write(0, 2, 0);
    host_write(1, 8'h11, 1);
    host_read(1, 0, "R3 write ignored");
    host_read(1, 1, "R3 read not driven");
    host_write(0, 7, 1);
    host_read(0, 0, "R3 index kept");
    // R10 pin control
    host_write(0, 10, 0);
    host_write(1, 8'h03, 0);
    chk("R10 pins wait for tick", int'(xout), 0);
    tick(8'h9C);
    chk("R10 pins after tick", int'(xout), 3);
    host_write(1, 8'hFE, 0);
    host_read(1, 0, "R10 readback");
    chk("R10 pins hold", int'(xout), 3);
    tick(8'h42);
    chk("R10 pins follow", int'(xout), 2);
    // R8 status after tick
    host_read(2, 0, "R8 status");
    // R7 capture inactive
    host_read(3, 0, "R7 inactive read");
    host_read(2, 0, "R7 flag kept");
    // R9 playback inactive, R6 single-bit
    host_write(3, 8'h21, 0);
    host_write(0, 9, 0);
    host_write(1, 8'h01, 0);
    host_write(3, 8'h22, 0);
    chk("R6 enable only", int'(dac_byte), 0);
    host_write(1, 8'h40, 0);
    host_write(3, 8'h23, 0);
    chk("R6 pio only", int'(dac_byte), 0);
    host_write(1, 8'h41, 0);
    host_write(3, 8'h5A, 0);
    chk("R9 dac loaded", int'(dac_byte), 8'h5A);
    host_read(2, 0, "R9 pb flag cleared");
    // R7 capture active
    host_write(0, 9, 0);
    host_write(1, 8'hC3, 0);
    host_read(3, 1, "R3 pio read ignored");
    host_read(2, 0, "R3 cap flag kept");
    host_read(3, 0, "R7 capture byte");
    host_read(2, 0, "R9 cap flag cleared");
    host_write(1, 8'h80, 0);
    tick(8'h66);
    host_read(3, 0, "R7 pio without enable");
    host_read(2, 0, "R7 flag stays");
    host_write(1, 8'h02, 0);
    host_read(3, 0, "R7 enable without pio");
    host_write(1, 8'hC3, 0);
    host_read(3, 0, "R8 newest sample");
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule